// File: doc/BRIEF.md
# Privilege and Illegal-Instruction Trap Unit

This block sits behind the instruction decoder and rules, once per valid decoded instruction, on one of three outcomes: execute it, stop the core, or raise a program-interrupt trap. The decision depends on the operation class, the high bit of the special-register number field, a flag from the decoder marking the word as illegal, and the problem-state bit of the machine state register.

When a trap is taken, the unit produces three values. The first save register receives the address of the faulting instruction. The second save register receives a copy of the old machine state register with a cause bit added. The new machine state register value has a fixed group of bits cleared and the 64-bit-mode and little-endian bits set. Fetch is redirected to the interrupt vector.

The attention operation, when it does not trap, puts the unit into a sticky halted state. In that state every later instruction is refused until reset. All results are registered and appear on the clock edge after the instruction is presented.

Top module: `prog_trap_unit`

## Requirements
- R1: The operation class is encoded on `op_class_i` as 0 other, 1 attention, 2 read-MSR, 3 write-MSR, 4 write-MSR-doubleword, 5 return-from-interrupt, 6 read-SPR, 7 write-SPR. Classes 1 to 5 are privileged without condition.
- R2: Classes 6 and 7 are privileged only when `spr_hi_i` is 1. Any other class with `spr_hi_i` set is not made privileged.
- R3: A privileged instruction with MSR problem-state bit (bit 14) equal to 0 is not trapped. An instruction of class 0, 2 to 7 that does not trap raises `exec_o`. `exec_o` and `trap_o` are never both 1.
- R4: A privileged instruction with MSR bit 14 equal to 1 traps and does not execute. `srr1_o` is then `msr_i` with bit 6 (the privileged cause) set.
- R5: A non-privileged-trapping instruction with `illegal_i` set traps, and `srr1_o` is `msr_i` with bit 7 (the illegal cause) set. When both causes apply, only the privileged cause is reported.
- R6: On a trap, `srr0_o` equals the `cia_i` of the trapping instruction.
- R7: On a trap, `trap_o` is 1 and `trap_pc_o` is 0x700.
- R8: On a trap, `msr_o` is `msr_i` with bits 0, 1, 2, 4, 5, 8, 9, 10, 11, 12, 13, 14, 15, 23, 25 and 32 cleared, bits 63 and 0... bit 63 set and bit 0 set (little-endian wins over its clear), all other bits unchanged. Only the saved copy carries a cause bit.
- R9: An attention instruction that does not trap sets `halted_o`, which stays 1 until reset. That instruction does not raise `exec_o`.
- R10: While `halted_o` is 1, `valid_i` is ignored: `exec_o` and `trap_o` stay 0 and all data outputs stay 0.
- R11: A trap takes priority over the halt: an illegal attention instruction with bit 14 equal to 0 traps with the illegal cause and does not halt.
- R12: All outputs reflect the instruction presented in the previous cycle. Without `valid_i`, `exec_o` and `trap_o` are 0 and `trap_pc_o`, `srr0_o`, `srr1_o` and `msr_o` are 0. With no trap, those four data outputs are also 0.
- R13: After reset, all outputs including `halted_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | A decoded instruction is presented |
| op_class_i | input | 4 | Operation class (encoding in R1) |
| spr_hi_i | input | 1 | High bit of the special-register number field |
| illegal_i | input | 1 | Decoder marks the instruction illegal |
| cia_i | input | 64 | Address of the presented instruction |
| msr_i | input | 64 | Current machine state register |
| exec_o | output | 1 | Instruction may execute |
| trap_o | output | 1 | Trap taken; strobe for save registers, MSR and redirect |
| trap_pc_o | output | 64 | Redirect address on trap |
| srr0_o | output | 64 | Value for save register 0 |
| srr1_o | output | 64 | Value for save register 1 |
| msr_o | output | 64 | New machine state register |
| halted_o | output | 1 | Sticky halted state |

## Verification
The halted state is the hardest situation to test. It is terminal, so once the stimulus reaches it, nothing else about the decision logic can be observed until reset. The bench therefore runs its directed and random vectors first. It then issues a clean attention instruction and follows it with trapping and executable instructions, which must all be refused. Finally it re-applies reset partway through the run and checks that the unit accepts work again. The contest between an illegal flag and attention with problem state clear is driven directly, because random stimulus rarely produces it.

// File: rtl/trap_pkg.sv
`timescale 1ns/1ps
package trap_pkg;
  typedef enum logic [3:0] {
    OPC_OTHER  = 4'd0,
    OPC_ATTN   = 4'd1,
    OPC_RDMSR  = 4'd2,
    OPC_WRMSR  = 4'd3,
    OPC_WRMSRD = 4'd4,
    OPC_RFI    = 4'd5,
    OPC_RDSPR  = 4'd6,
    OPC_WRSPR  = 4'd7
  } op_class_e;
endpackage

// File: rtl/trap_priv_dec.sv
`timescale 1ns/1ps
module trap_priv_dec
  import trap_pkg::*;
(
  input  logic [3:0] op_class_i,
  input  logic       spr_hi_i,
  output logic       priv_o,
  output logic       attn_o
);
  op_class_e cls;
  assign cls = op_class_e'(op_class_i);

  always_comb begin
    priv_o = 1'b0;
    case (cls)
      OPC_ATTN, OPC_RDMSR, OPC_WRMSR, OPC_WRMSRD, OPC_RFI: priv_o = 1'b1;
      OPC_RDSPR, OPC_WRSPR:                                 priv_o = spr_hi_i;
      default:                                              priv_o = 1'b0;
    endcase
  end

  assign attn_o = (cls == OPC_ATTN);
endmodule

// File: rtl/trap_msr_xform.sv
`timescale 1ns/1ps
module trap_msr_xform #(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned SF_BIT     = 63,
  parameter int unsigned TM_BIT     = 32,
  parameter int unsigned VEC_BIT    = 25,
  parameter int unsigned VSX_BIT    = 23,
  parameter int unsigned EE_BIT     = 15,
  parameter int unsigned PR_BIT     = 14,
  parameter int unsigned FP_BIT     = 13,
  parameter int unsigned UND_BIT    = 12,
  parameter int unsigned FE0_BIT    = 11,
  parameter int unsigned TES_BIT    = 10,
  parameter int unsigned TEE_BIT    = 9,
  parameter int unsigned FE1_BIT    = 8,
  parameter int unsigned IR_BIT     = 5,
  parameter int unsigned DR_BIT     = 4,
  parameter int unsigned PMM_BIT    = 2,
  parameter int unsigned RI_BIT     = 1,
  parameter int unsigned LE_BIT     = 0,
  parameter int unsigned CAUSE_ILL  = 7,
  parameter int unsigned CAUSE_PRIV = 6
) (
  input  logic [XLEN-1:0] msr_i,
  input  logic            cause_priv_i,
  output logic [XLEN-1:0] msr_new_o,
  output logic [XLEN-1:0] srr1_o
);
  localparam logic [XLEN-1:0] ONE = XLEN'(1);
  localparam logic [XLEN-1:0] CLR_MASK =
      (ONE << TM_BIT)  | (ONE << VEC_BIT) | (ONE << VSX_BIT) | (ONE << EE_BIT)  |
      (ONE << PR_BIT)  | (ONE << FP_BIT)  | (ONE << UND_BIT) | (ONE << FE0_BIT) |
      (ONE << TES_BIT) | (ONE << TEE_BIT) | (ONE << FE1_BIT) | (ONE << IR_BIT)  |
      (ONE << DR_BIT)  | (ONE << PMM_BIT) | (ONE << RI_BIT);
  localparam logic [XLEN-1:0] SET_MASK = (ONE << SF_BIT) | (ONE << LE_BIT);

  assign msr_new_o = (msr_i & ~CLR_MASK) | SET_MASK;
  // cause lands only in the saved copy
  assign srr1_o    = msr_i | (cause_priv_i ? (ONE << CAUSE_PRIV) : (ONE << CAUSE_ILL));
endmodule

// File: rtl/prog_trap_unit.sv
`timescale 1ns/1ps
module prog_trap_unit #(
  parameter int unsigned XLEN       = 64,
  parameter logic [63:0] VEC_ADDR   = 64'h700,
  parameter int unsigned SF_BIT     = 63,
  parameter int unsigned TM_BIT     = 32,
  parameter int unsigned VEC_BIT    = 25,
  parameter int unsigned VSX_BIT    = 23,
  parameter int unsigned EE_BIT     = 15,
  parameter int unsigned PR_BIT     = 14,
  parameter int unsigned FP_BIT     = 13,
  parameter int unsigned UND_BIT    = 12,
  parameter int unsigned FE0_BIT    = 11,
  parameter int unsigned TES_BIT    = 10,
  parameter int unsigned TEE_BIT    = 9,
  parameter int unsigned FE1_BIT    = 8,
  parameter int unsigned IR_BIT     = 5,
  parameter int unsigned DR_BIT     = 4,
  parameter int unsigned PMM_BIT    = 2,
  parameter int unsigned RI_BIT     = 1,
  parameter int unsigned LE_BIT     = 0,
  parameter int unsigned CAUSE_ILL  = 7,
  parameter int unsigned CAUSE_PRIV = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [3:0]      op_class_i,
  input  logic            spr_hi_i,
  input  logic            illegal_i,
  input  logic [XLEN-1:0] cia_i,
  input  logic [XLEN-1:0] msr_i,
  output logic            exec_o,
  output logic            trap_o,
  output logic [XLEN-1:0] trap_pc_o,
  output logic [XLEN-1:0] srr0_o,
  output logic [XLEN-1:0] srr1_o,
  output logic [XLEN-1:0] msr_o,
  output logic            halted_o
);
  localparam logic [XLEN-1:0] ONE = XLEN'(1);

  logic            priv, attn;
  logic            live, priv_trap, ill_trap, take_trap, take_halt, take_exec;
  logic [XLEN-1:0] msr_new, srr1_new;
  logic            halted_q;

  trap_priv_dec i_dec (
    .op_class_i (op_class_i),
    .spr_hi_i   (spr_hi_i),
    .priv_o     (priv),
    .attn_o     (attn)
  );

  trap_msr_xform #(
    .XLEN(XLEN), .SF_BIT(SF_BIT), .TM_BIT(TM_BIT), .VEC_BIT(VEC_BIT),
    .VSX_BIT(VSX_BIT), .EE_BIT(EE_BIT), .PR_BIT(PR_BIT), .FP_BIT(FP_BIT),
    .UND_BIT(UND_BIT), .FE0_BIT(FE0_BIT), .TES_BIT(TES_BIT), .TEE_BIT(TEE_BIT),
    .FE1_BIT(FE1_BIT), .IR_BIT(IR_BIT), .DR_BIT(DR_BIT), .PMM_BIT(PMM_BIT),
    .RI_BIT(RI_BIT), .LE_BIT(LE_BIT), .CAUSE_ILL(CAUSE_ILL), .CAUSE_PRIV(CAUSE_PRIV)
  ) i_xform (
    .msr_i        (msr_i),
    .cause_priv_i (priv_trap),
    .msr_new_o    (msr_new),
    .srr1_o       (srr1_new)
  );

  assign live      = valid_i && !halted_q;
  assign priv_trap = live && priv && msr_i[PR_BIT];
  assign ill_trap  = live && !priv_trap && illegal_i;
  assign take_trap = priv_trap || ill_trap;
  // trap outranks halt
  assign take_halt = live && !take_trap && attn;
  assign take_exec = live && !take_trap && !attn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halted_q  <= 1'b0;
      exec_o    <= 1'b0;
      trap_o    <= 1'b0;
      trap_pc_o <= '0;
      srr0_o    <= '0;
      srr1_o    <= '0;
      msr_o     <= '0;
    end else begin
      if (take_halt) halted_q <= 1'b1;
      exec_o    <= take_exec;
      trap_o    <= take_trap;
      trap_pc_o <= take_trap ? VEC_ADDR[XLEN-1:0] : '0;
      srr0_o    <= take_trap ? cia_i : '0;
      srr1_o    <= take_trap ? srr1_new : '0;
      msr_o     <= take_trap ? msr_new : '0;
    end
  end

  assign halted_o = halted_q;

  p_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exec_o && trap_o));

  p_vector_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> trap_pc_o == VEC_ADDR[XLEN-1:0]);

  p_save_pc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> srr0_o == $past(cia_i));

  p_one_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $countones((srr1_o ^ $past(msr_i)) &
                          ((ONE << CAUSE_ILL) | (ONE << CAUSE_PRIV))) <= 1);

  p_msr_fixed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> msr_o[SF_BIT] && msr_o[LE_BIT] && !msr_o[PR_BIT] && !msr_o[EE_BIT]);

  p_halt_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);

  p_halt_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> !exec_o && !trap_o);

  p_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !exec_o && !trap_o);
endmodule

// File: tb/test_prog_trap_unit.sv
`timescale 1ns/1ps
module test_prog_trap_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  cls = 4'd0;
  logic        sh = 1'b0;
  logic        ill = 1'b0;
  logic [63:0] cia = '0;
  logic [63:0] msr = '0;
  logic        exec_w, trap_w, halted_w;
  logic [63:0] tpc_w, srr0_w, srr1_w, msr_w;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;
  bit halted_m = 0;

  // expected, computed from the requirements
  logic        e_exec, e_trap;
  logic [63:0] e_tpc, e_srr0, e_srr1, e_msr;

  always #10 clk = ~clk;

  prog_trap_unit i_prog_trap_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_class_i(cls),
    .spr_hi_i(sh), .illegal_i(ill), .cia_i(cia), .msr_i(msr),
    .exec_o(exec_w), .trap_o(trap_w), .trap_pc_o(tpc_w), .srr0_o(srr0_w),
    .srr1_o(srr1_w), .msr_o(msr_w), .halted_o(halted_w)
  );

  function automatic logic [63:0] bits(input int b);
    return 64'd1 << b;
  endfunction

  function automatic logic [63:0] trap_msr(input logic [63:0] m);
    logic [63:0] clr;
    clr = bits(0) | bits(1) | bits(2) | bits(4) | bits(5) | bits(8) | bits(9) |
          bits(10) | bits(11) | bits(12) | bits(13) | bits(14) | bits(15) |
          bits(23) | bits(25) | bits(32);
    return (m & ~clr) | bits(63) | bits(0);
  endfunction

  task automatic chk(input string req, input string fld, input logic [63:0] act,
                     input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", req, fld, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string req);
    chk(req, "exec",   {63'd0, exec_w},   {63'd0, e_exec});
    chk(req, "trap",   {63'd0, trap_w},   {63'd0, e_trap});
    chk(req, "trappc", tpc_w,  e_tpc);
    chk(req, "srr0",   srr0_w, e_srr0);
    chk(req, "srr1",   srr1_w, e_srr1);
    chk(req, "msr",    msr_w,  e_msr);
    chk(req, "halted", {63'd0, halted_w}, {63'd0, halted_m});
  endtask

  // called at a falling edge: drive, model, wait for the result, compare
  task automatic step(input string req, input logic v, input logic [3:0] c,
                      input logic s, input logic il, input logic [63:0] a,
                      input logic [63:0] m);
    logic p;
    valid = v; cls = c; sh = s; ill = il; cia = a; msr = m;
    p = (c >= 4'd1 && c <= 4'd5) || ((c == 4'd6 || c == 4'd7) && s);
    e_exec = 0; e_trap = 0; e_tpc = 0; e_srr0 = 0; e_srr1 = 0; e_msr = 0;
    if (v && !halted_m) begin
      if ((p && m[14]) || il) begin
        e_trap = 1; e_tpc = 64'h700; e_srr0 = a; e_msr = trap_msr(m);
        e_srr1 = (p && m[14]) ? (m | bits(6)) : (m | bits(7));
      end else if (c == 4'd1) begin
        halted_m = 1;
      end else begin
        e_exec = 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare_all(req);
  endtask

  task automatic reset_check();
    rst_n = 1'b0;
    valid = 0;
    halted_m = 0;
    e_exec = 0; e_trap = 0; e_tpc = 0; e_srr0 = 0; e_srr1 = 0; e_msr = 0;
    @(negedge clk);
    compare_all("R13");
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    reset_check();
    // R12 idle
    step("R12", 0, 4'd3, 0, 1, 64'h10, bits(14));
    // R1 always-privileged classes
    for (int c = 1; c <= 5; c++) step("R1", 1, c[3:0], 0, 0, 64'h1000 + c, bits(14) | 64'hF0F0);
    // R2 SPR classes
    step("R2", 1, 4'd6, 0, 0, 64'h2000, bits(14));
    step("R2", 1, 4'd6, 1, 0, 64'h2004, bits(14));
    step("R2", 1, 4'd7, 1, 0, 64'h2008, bits(14) | bits(63));
    step("R2", 1, 4'd7, 0, 0, 64'h200c, bits(14));
    step("R2", 1, 4'd0, 1, 0, 64'h2010, bits(14));
    // R3 privileged with PR clear executes
    step("R3", 1, 4'd2, 0, 0, 64'h3000, 64'h0);
    step("R3", 1, 4'd7, 1, 0, 64'h3004, 64'hFFFF_0000_0000_0000);
    // R4 cause already set in msr, all-ones msr
    step("R4", 1, 4'd5, 0, 0, 64'h4000, 64'hFFFF_FFFF_FFFF_FFFF);
    step("R4", 1, 4'd3, 0, 0, 64'h4004, bits(14) | bits(6));
    // R5 illegal, and both causes
    step("R5", 1, 4'd0, 0, 1, 64'h5000, 64'h0);
    step("R5", 1, 4'd4, 0, 1, 64'h5004, bits(14));
    step("R5", 1, 4'd6, 1, 1, 64'h5008, 64'h0);
    // R6, R7, R8 trap contents
    step("R6", 1, 4'd0, 0, 1, 64'hDEAD_BEEF_0000_1234, 64'h1234_5678_9ABC_DEF0);
    step("R7", 1, 4'd2, 0, 0, 64'h7000, bits(14));
    step("R8", 1, 4'd0, 0, 1, 64'h8000, 64'hAAAA_AAAA_AAAA_AAAA);
    step("R8", 1, 4'd0, 0, 1, 64'h8004, 64'h5555_5555_5555_5555);
    // R11 illegal attention with PR clear traps, no halt
    step("R11", 1, 4'd1, 0, 1, 64'hB000, 64'h0);
    step("R11", 1, 4'd0, 0, 0, 64'hB004, 64'h0);
    // random mix, attention without trap excluded here
    for (int i = 0; i < 400; i++) begin
      logic [3:0] rc;
      logic [63:0] rm;
      logic ri;
      rc = 4'($urandom_range(0, 9));
      rm = {$urandom, $urandom};
      ri = ($urandom_range(0, 5) == 0);
      if (rc == 4'd1 && !rm[14] && !ri) rm[14] = 1'b1;
      step("R12", $urandom_range(0, 3) != 0, rc, 1'($urandom), ri,
           {$urandom, $urandom}, rm);
    end
    // R9 halt, then R10 refuse everything
    step("R9", 1, 4'd1, 0, 0, 64'h9000, 64'h0);
    step("R9", 0, 4'd0, 0, 0, 64'h9004, 64'h0);
    step("R10", 1, 4'd0, 0, 0, 64'hA000, 64'h0);
    step("R10", 1, 4'd3, 0, 0, 64'hA004, bits(14));
    step("R10", 1, 4'd0, 0, 1, 64'hA008, 64'h0);
    // R13 reset clears halt, unit works again
    reset_check();
    step("R13", 1, 4'd0, 0, 0, 64'hC000, 64'h0);
    step("R13", 1, 4'd0, 0, 1, 64'hC004, 64'h0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule